// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

One DMA channel. The sequencer decides when a transfer unit may start. It produces the source and destination addresses for each unit. It counts units against a repeat or block size and against an optional total byte limit. A start can come from one of three places: the channel itself, which runs continuously once enabled; a peripheral interrupt whose vector number matches a programmed selector; or a level-sensitive external request pin.

Every transfer unit is one bus handshake. The channel raises `busReq` with both addresses and the unit size, and the bus answers with `busAck`. In single-address form, one side of the transfer is an external device. That device is selected by `dackOut` instead of an address register, and its address is never stepped. Software programs the channel through a small register write port and reads back the working state through a read port.

Register map (word offsets on `wrAddr`/`rdAddr`):

| Offset | Write | Read |
|---|---|---|
| 0 | source start address | current source address |
| 1 | destination start address | current destination address |
| 2 | size minus one | remaining size minus one |
| 3 | total bytes minus one | remaining total |
| 4 | offset | offset |
| 5 | control | control |
| 6 | vector select | vector select |

A write to offset 0, 1, 2 or 3 loads both the start value and the working copy.

Control word fields:

| Bits | Field | Encoding |
|---|---|---|
| [0] | enable | |
| [2:1] | source | 0 auto, 1 on-chip, 2 external |
| [4:3] | mode | 0 normal, 1 repeat, 2 block |
| [6:5] | unit | 0 byte, 1 word, 2 longword |
| [8:7] | source step | 0 fixed, 1 increment, 2 decrement |
| [10:9] | destination step | same encoding as source step |
| [11] | single-address | |
| [12] | device side | 0 device is the source, 1 device is the destination |
| [13] | offset addition | |
| [14] | total limit enable | |

Top module: `dma_chan_seq`

## Requirements
- R1: After reset `busReq`, `dackOut` and `done` are low, and every read-back register is zero, including the control enable bit (bit 0).
- R2: With source = 0 (auto), an enabled channel starts transfers with no request input.
- R3: With source = 1 (on-chip), a transfer starts only when `irqValid` is high and `irqVector` equals the vector select register. A vector select of 0 never starts a transfer, and a non-matching vector has no effect on the addresses.
- R4: With source = 2 (external), a high `extReq` starts a transfer.
- R5: Without offset addition, each side steps by the unit size (1, 2 or 4 bytes for unit 0, 1, 2). A side set to fixed (0) keeps its address, a side set to increment (1) adds the step, and a side set to decrement (2) subtracts it.
- R6: With offset addition (bit 13), the offset register replaces the unit-size step on every side that is not fixed.
- R7: In normal mode (0), each granted request moves exactly one unit.
- R8: In block mode (2), one request moves size+1 units back to back. The channel then waits for the next request.
- R9: In repeat mode (1), the move after the (size+1)th unit reloads both addresses and the size counter from their start values, and the channel keeps running.
- R10: In single-address mode (bit 11), `dackOut` is high during each bus request and the device-side address never steps. In dual-address mode `dackOut` stays low.
- R11: With the limit enabled (bit 14) and a programmed total of T bytes, the channel performs ceil(T/unit) transfers. On the final acknowledge it clears the enable bit, and `done` is high for exactly one cycle, in the cycle after that acknowledge.
- R12: `busReq` stays high, with stable addresses, until `busAck` is seen.
- R13: With the limit disabled the channel never raises `done` and keeps running until software clears enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low asynchronous reset |
| wrEn | input | 1 | register write strobe |
| wrAddr | input | 3 | register write offset |
| wrData | input | 32 | register write data |
| rdAddr | input | 3 | register read offset |
| rdData | output | 32 | register read data (combinational) |
| irqValid | input | 1 | peripheral interrupt present |
| irqVector | input | 8 | vector number of the present interrupt |
| extReq | input | 1 | external request level |
| busReq | output | 1 | transfer unit request to the bus |
| busAck | input | 1 | bus accepts the current unit |
| busSrcAddr | output | 32 | source address of the current unit |
| busDstAddr | output | 32 | destination address of the current unit |
| busSize | output | 2 | unit size code |
| dackOut | output | 1 | external device acknowledge (single-address mode) |
| done | output | 1 | one-cycle pulse when the total is exhausted |

## Verification
A corrupted working address shows up at the very next acknowledge, as a wrong `busSrcAddr` or `busDstAddr` compared against the scoreboard. A wrong size or total counter shows up at the end of a block, a repeat period or a run. It appears there as an extra or missing transfer, a missing reload, or a `done` pulse that comes at the wrong time or never comes. A wrong trigger decision appears within a few cycles as a transfer nobody expected, or as a queue that never drains.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int REG_SRC  = 0;
  localparam int REG_DST  = 1;
  localparam int REG_SIZE = 2;
  localparam int REG_TOT  = 3;
  localparam int REG_OFS  = 4;
  localparam int REG_CTRL = 5;
  localparam int REG_VEC  = 6;

  typedef enum logic [1:0] {SRC_AUTO = 2'd0, SRC_ONCHIP = 2'd1, SRC_EXT = 2'd2, SRC_NONE = 2'd3} reqSrc_e;
  typedef enum logic [1:0] {MODE_NORMAL = 2'd0, MODE_REPEAT = 2'd1, MODE_BLOCK = 2'd2, MODE_RSVD = 2'd3} xferMode_e;
  typedef enum logic [1:0] {STEP_FIXED = 2'd0, STEP_INC = 2'd1, STEP_DEC = 2'd2, STEP_RSVD = 2'd3} stepMode_e;

  typedef struct packed {
    logic      limitEn;
    logic      offsetEn;
    logic      devIsDst;
    logic      single;
    stepMode_e dstStep;
    stepMode_e srcStep;
    logic [1:0] unit;
    xferMode_e mode;
    reqSrc_e   src;
  } chanCfg_t;

  typedef struct packed {
    logic step;
    logic reload;
  } seqStrobe_t;

endpackage

// File: rtl/dma_seq_dpath.sv
module dma_seq_dpath
  import dma_seq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16,
  parameter int VEC_W = 8,
  parameter int RA_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [RA_W-1:0]  wrAddr,
  input  logic [AW-1:0]    wrData,
  input  logic [RA_W-1:0]  rdAddr,
  output logic [AW-1:0]    rdData,
  input  seqStrobe_t       strb,
  input  logic             enable,
  output chanCfg_t         cfg,
  output logic [VEC_W-1:0] vecSel,
  output logic             blkLast,
  output logic             totLast,
  output logic [AW-1:0]    srcAddr,
  output logic [AW-1:0]    dstAddr
);

  localparam int CFG_W = $bits(chanCfg_t);

  logic [AW-1:0]    srcInit, dstInit, totRem, offsetReg;
  logic [CNT_W-1:0] sizeInit, blkRem;
  logic [AW-1:0]    unitBytes, delta;
  logic             srcIsDev, dstIsDev;
  logic             srcWr, dstWr;

  assign srcWr = wrEn && (wrAddr == RA_W'(REG_SRC));
  assign dstWr = wrEn && (wrAddr == RA_W'(REG_DST));

  always_comb begin
    case (cfg.unit)
      2'd0:    unitBytes = AW'(1);
      2'd1:    unitBytes = AW'(2);
      default: unitBytes = AW'(4);
    endcase
  end

  assign delta    = cfg.offsetEn ? offsetReg : unitBytes;
  assign srcIsDev = cfg.single && !cfg.devIsDst;
  assign dstIsDev = cfg.single && cfg.devIsDst;
  assign blkLast  = (blkRem == '0);
  assign totLast  = cfg.limitEn && (totRem < unitBytes);

  function automatic logic [AW-1:0] stepAddr(input logic [AW-1:0] a, input stepMode_e m,
                                              input logic [AW-1:0] d);
    case (m)
      STEP_INC: stepAddr = a + d;
      STEP_DEC: stepAddr = a - d;
      default:  stepAddr = a;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcInit   <= '0;
      dstInit   <= '0;
      srcAddr   <= '0;
      dstAddr   <= '0;
      sizeInit  <= '0;
      blkRem    <= '0;
      totRem    <= '0;
      offsetReg <= '0;
      cfg       <= '0;
      vecSel    <= '0;
    end else begin
      if (strb.step) begin
        if (strb.reload) begin
          srcAddr <= srcInit;
          dstAddr <= dstInit;
        end else begin
          if (!srcIsDev) srcAddr <= stepAddr(srcAddr, cfg.srcStep, delta);
          if (!dstIsDev) dstAddr <= stepAddr(dstAddr, cfg.dstStep, delta);
        end
        blkRem <= blkLast ? sizeInit : blkRem - 1'b1;
        if (cfg.limitEn) totRem <= totRem - unitBytes;
      end
      if (wrEn) begin
        case (int'(wrAddr))
          REG_SRC:  begin srcInit <= wrData; srcAddr <= wrData; end
          REG_DST:  begin dstInit <= wrData; dstAddr <= wrData; end
          REG_SIZE: begin sizeInit <= wrData[CNT_W-1:0]; blkRem <= wrData[CNT_W-1:0]; end
          REG_TOT:  totRem <= wrData;
          REG_OFS:  offsetReg <= wrData;
          REG_CTRL: cfg <= chanCfg_t'(wrData[CFG_W:1]);
          REG_VEC:  vecSel <= wrData[VEC_W-1:0];
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (int'(rdAddr))
      REG_SRC:  rdData = srcAddr;
      REG_DST:  rdData = dstAddr;
      REG_SIZE: rdData = AW'(blkRem);
      REG_TOT:  rdData = totRem;
      REG_OFS:  rdData = offsetReg;
      REG_CTRL: rdData = AW'({cfg, enable});
      REG_VEC:  rdData = AW'(vecSel);
      default:  rdData = '0;
    endcase
  end

  AST_FIXED_SRC_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.reload && cfg.srcStep == STEP_FIXED && !srcWr && !wrEn) |=> $stable(srcAddr)) // R5
    else $error("fixed source address moved");

  AST_ADDR_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.step && !srcWr && !dstWr) |=> ($stable(srcAddr) && $stable(dstAddr))) // R12
    else $error("address changed without a transfer");

  AST_DEV_SIDE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.reload && srcIsDev && !wrEn) |=> $stable(srcAddr)) // R10
    else $error("device-side address stepped");

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanCfg_t         cfg,
  input  logic [VEC_W-1:0] vecSel,
  input  logic             ctrlWr,
  input  logic             ctrlWrEn,
  input  logic             irqValid,
  input  logic [VEC_W-1:0] irqVector,
  input  logic             extReq,
  input  logic             busAck,
  input  logic             blkLast,
  input  logic             totLast,
  output logic             busReq,
  output logic             dackOut,
  output logic             done,
  output logic             enable,
  output seqStrobe_t       strb
);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_XFER} seqState_e;
  seqState_e state;
  logic trig, ackNow, endRun;

  always_comb begin
    case (cfg.src)
      SRC_AUTO:   trig = 1'b1;
      SRC_ONCHIP: trig = irqValid && (vecSel != '0) && (irqVector == vecSel);
      SRC_EXT:    trig = extReq;
      default:    trig = 1'b0;
    endcase
  end

  assign busReq      = (state == ST_XFER);
  assign dackOut     = busReq && cfg.single;
  assign ackNow      = busReq && busAck;
  assign strb.step   = ackNow;
  assign strb.reload = ackNow && (cfg.mode == MODE_REPEAT) && blkLast;
  assign endRun      = ackNow && totLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      enable <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= endRun;
      if (ctrlWr)      enable <= ctrlWrEn;
      else if (endRun) enable <= 1'b0;
      case (state)
        ST_IDLE: if (enable) state <= ST_WAIT;
        ST_WAIT: begin
          if (!enable)   state <= ST_IDLE;
          else if (trig) state <= ST_XFER;
        end
        ST_XFER: begin
          if (busAck) begin
            if (totLast || !enable)                        state <= ST_IDLE;
            else if (cfg.mode == MODE_BLOCK && !blkLast)   state <= ST_XFER;
            else                                           state <= ST_WAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> busReq) // R12
    else $error("request dropped before acknowledge");

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) // R11
    else $error("done longer than one cycle");

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busReq && busAck)) // R11
    else $error("done without a final acknowledge");

  AST_VEC_ZERO_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && cfg.src == SRC_ONCHIP && vecSel == '0) |=> !busReq) // R3
    else $error("zero vector select started a transfer");

  AST_BLOCK_CONTINUES: assert property (@(posedge clk) disable iff (!rstN)
    (ackNow && cfg.mode == MODE_BLOCK && !blkLast && !totLast && enable && !ctrlWr) |=> busReq) // R8
    else $error("block stopped early");

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16,
  parameter int VEC_W = 8,
  parameter int RA_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [RA_W-1:0]  wrAddr,
  input  logic [AW-1:0]    wrData,
  input  logic [RA_W-1:0]  rdAddr,
  output logic [AW-1:0]    rdData,
  input  logic             irqValid,
  input  logic [VEC_W-1:0] irqVector,
  input  logic             extReq,
  output logic             busReq,
  input  logic             busAck,
  output logic [AW-1:0]    busSrcAddr,
  output logic [AW-1:0]    busDstAddr,
  output logic [1:0]       busSize,
  output logic             dackOut,
  output logic             done
);

  chanCfg_t         cfg;
  seqStrobe_t       strb;
  logic [VEC_W-1:0] vecSel;
  logic             blkLast, totLast, enable, ctrlWr;

  assign ctrlWr  = wrEn && (wrAddr == RA_W'(REG_CTRL));
  assign busSize = cfg.unit;

  dma_seq_dpath #(.AW(AW), .CNT_W(CNT_W), .VEC_W(VEC_W), .RA_W(RA_W)) uDpath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .strb(strb), .enable(enable), .cfg(cfg),
    .vecSel(vecSel), .blkLast(blkLast), .totLast(totLast),
    .srcAddr(busSrcAddr), .dstAddr(busDstAddr)
  );

  dma_seq_ctrl #(.VEC_W(VEC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .vecSel(vecSel), .ctrlWr(ctrlWr),
    .ctrlWrEn(wrData[0]), .irqValid(irqValid), .irqVector(irqVector),
    .extReq(extReq), .busAck(busAck), .blkLast(blkLast), .totLast(totLast),
    .busReq(busReq), .dackOut(dackOut), .done(done), .enable(enable), .strb(strb)
  );

endmodule

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        irqValid = 1'b0;
  logic [7:0]  irqVector = '0;
  logic        extReq = 1'b0;
  logic        busReq, busAck = 1'b0, dackOut, done;
  logic [31:0] busSrcAddr, busDstAddr;
  logic [1:0]  busSize;

  always #2.5 clk = ~clk;

  dma_chan_seq uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irqValid(irqValid), .irqVector(irqVector),
    .extReq(extReq), .busReq(busReq), .busAck(busAck), .busSrcAddr(busSrcAddr),
    .busDstAddr(busDstAddr), .busSize(busSize), .dackOut(dackOut), .done(done)
  );

  typedef struct {
    logic [31:0] src;
    logic [31:0] dst;
    logic        dack;
    string       tag;
  } xferItem_t;

  xferItem_t expQ[$];
  int testsRun = 0, testsFailed = 0, doneCnt = 0, ackLat = 0, waitCnt = 0;
  logic [31:0] snapS, snapD;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expectXfer(input logic [31:0] s, input logic [31:0] d, input logic k, input string tag);
    xferItem_t it;
    it.src = s; it.dst = d; it.dack = k; it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor and bus responder
  always @(negedge clk) begin
    if (done) doneCnt++;
    if (busReq) begin
      if (waitCnt == 0) begin
        snapS = busSrcAddr; snapD = busDstAddr;
      end else begin
        check("R12 src stable", busSrcAddr, snapS);
        check("R12 dst stable", busDstAddr, snapD);
      end
      if (waitCnt < ackLat) begin
        busAck = 1'b0;
        waitCnt++;
      end else begin
        if (expQ.size() == 0) begin
          testsRun++; testsFailed++;
          $display("FAIL unexpected transfer actual=%h/%h expected=none", busSrcAddr, busDstAddr);
        end else begin
          xferItem_t it;
          it = expQ.pop_front();
          check({it.tag, " src"}, busSrcAddr, it.src);
          check({it.tag, " dst"}, busDstAddr, it.dst);
          check({it.tag, " dack"}, {31'd0, dackOut}, {31'd0, it.dack});
        end
        busAck = 1'b1;
        waitCnt = 0;
      end
    end else begin
      busAck = 1'b0;
      waitCnt = 0;
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rdAddr = 3'(a);
    #1 d = rdData;
  endtask

  function automatic logic [31:0] mkCtrl(input int en, input int src, input int mode, input int unit,
                                         input int ss, input int ds, input int single, input int devDst,
                                         input int ofs, input int lim);
    return 32'(en) | 32'(src << 1) | 32'(mode << 3) | 32'(unit << 5) | 32'(ss << 7) |
           32'(ds << 9) | 32'(single << 11) | 32'(devDst << 12) | 32'(ofs << 13) | 32'(lim << 14);
  endfunction

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] sz,
                       input logic [31:0] tot, input logic [31:0] ofs, input logic [31:0] vec);
    wr(0, s); wr(1, d); wr(2, sz); wr(3, tot); wr(4, ofs); wr(6, vec);
  endtask

  task automatic finishRun(input string tag, input int expDone, input int d0, input logic expEn);
    logic [31:0] v;
    repeat (40) @(negedge clk);
    check({tag, " queue drained"}, 32'(expQ.size()), 0);
    check({tag, " done pulses"}, 32'(doneCnt - d0), 32'(expDone));
    rd(5, v);
    check({tag, " enable bit"}, {31'd0, v[0]}, {31'd0, expEn});
  endtask

  initial begin
    logic [31:0] v;
    int d0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 busReq", {31'd0, busReq}, 0);
    check("R1 dackOut", {31'd0, dackOut}, 0);
    check("R1 done", {31'd0, done}, 0);
    for (int a = 0; a < 7; a++) begin
      rd(a, v);
      check("R1 readback", v, 0);
    end

    // R2 R5 R7 R11: auto, byte, both increment, total 4 bytes
    setup(32'h1000, 32'h2000, 0, 3, 0, 0);
    for (int i = 0; i < 4; i++) expectXfer(32'h1000 + i, 32'h2000 + i, 1'b0, "R2 R5 R7 auto byte");
    d0 = doneCnt;
    wr(5, mkCtrl(1, 0, 0, 0, 1, 1, 0, 0, 0, 1));
    finishRun("R11 auto", 1, d0, 1'b0);

    // R5 R12: word, source decrement, destination fixed, total 6 bytes, slow ack
    ackLat = 2;
    setup(32'h1000, 32'h2000, 0, 5, 0, 0);
    for (int i = 0; i < 3; i++) expectXfer(32'h1000 - 2 * i, 32'h2000, 1'b0, "R5 word dec fixed");
    d0 = doneCnt;
    wr(5, mkCtrl(1, 0, 0, 1, 2, 0, 0, 0, 0, 1));
    finishRun("R11 word", 1, d0, 1'b0);
    ackLat = 0;

    // R3: on-chip vector select
    setup(32'h100, 32'h200, 0, 7, 0, 8'h21);
    d0 = doneCnt;
    wr(5, mkCtrl(1, 1, 0, 2, 1, 1, 0, 0, 0, 1));
    repeat (4) @(negedge clk);
    irqValid = 1'b1; irqVector = 8'h22;
    @(negedge clk); irqValid = 1'b0;
    repeat (6) @(negedge clk);
    rd(0, v);
    check("R3 wrong vector ignored", v, 32'h100);
    expectXfer(32'h100, 32'h200, 1'b0, "R3 R7 match 1");
    irqValid = 1'b1; irqVector = 8'h21;
    @(negedge clk); irqValid = 1'b0;
    repeat (6) @(negedge clk);
    rd(0, v);
    check("R7 one unit per request", v, 32'h104);
    expectXfer(32'h104, 32'h204, 1'b0, "R3 match 2");
    irqValid = 1'b1;
    @(negedge clk); irqValid = 1'b0;
    finishRun("R3 onchip", 1, d0, 1'b0);

    // R3: vector select 0 never triggers
    setup(32'h100, 32'h200, 0, 7, 0, 0);
    d0 = doneCnt;
    wr(5, mkCtrl(1, 1, 0, 2, 1, 1, 0, 0, 0, 1));
    irqValid = 1'b1; irqVector = 8'h00;
    repeat (8) @(negedge clk);
    irqValid = 1'b0;
    finishRun("R3 zero select", 0, d0, 1'b1);
    wr(5, 0);

    // R4 R8 R13: external request, block of 4 longwords, no limit
    setup(32'h4000, 32'h8000, 3, 0, 0, 0);
    for (int i = 0; i < 4; i++) expectXfer(32'h4000 + 4 * i, 32'h8000 + 4 * i, 1'b0, "R4 R8 block");
    d0 = doneCnt;
    wr(5, mkCtrl(1, 2, 2, 2, 1, 1, 0, 0, 0, 0));
    repeat (3) @(negedge clk);
    extReq = 1'b1;
    @(negedge clk); extReq = 1'b0;
    finishRun("R8 R13 block", 0, d0, 1'b1);
    wr(5, 0);

    // R9: repeat size 2 bytes, source increment, destination fixed, total 6 bytes
    setup(32'h40, 32'h80, 1, 5, 0, 0);
    for (int r = 0; r < 3; r++)
      for (int i = 0; i < 2; i++) expectXfer(32'h40 + i, 32'h80, 1'b0, "R9 repeat");
    d0 = doneCnt;
    wr(5, mkCtrl(1, 0, 1, 0, 1, 0, 0, 0, 0, 1));
    finishRun("R9 repeat", 1, d0, 1'b0);
    rd(0, v);
    check("R9 reloaded source", v, 32'h40);

    // R6: offset addition
    setup(32'h1000, 32'h3000, 0, 11, 32'h10, 0);
    for (int i = 0; i < 3; i++) expectXfer(32'h1000 + 16 * i, 32'h3000 - 16 * i, 1'b0, "R6 offset");
    d0 = doneCnt;
    wr(5, mkCtrl(1, 0, 0, 2, 1, 2, 0, 0, 1, 1));
    finishRun("R6 offset", 1, d0, 1'b0);

    // R10: single address, device is source
    setup(32'h500, 32'h300, 0, 3, 0, 0);
    for (int i = 0; i < 2; i++) expectXfer(32'h500, 32'h300 + 2 * i, 1'b1, "R10 single");
    d0 = doneCnt;
    wr(5, mkCtrl(1, 0, 0, 1, 1, 1, 1, 0, 0, 1));
    finishRun("R10 single", 1, d0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++; testsFailed++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule